// File: doc/BRIEF.md
# Peripheral Clock Gate Register Bank

This block holds one clock-enable bit per peripheral, up to 64 of them, and drives those bits straight out as gating enables for the peripherals' clock logic. Software sets and clears individual enables through a small synchronous register port. Each enable is set by writing a one to its bit in a set register and cleared by writing a one to its bit in a clear register. A status register shows the live enables. Because of this scheme, no read-modify-write is needed and concurrent software agents cannot undo each other's changes.

Enables are arranged in banks of 32. Peripheral number `p` lives in bank `p / 32` at bit `p % 32`. The two lowest peripheral numbers belong to always-running functions. They read as enabled at all times, and set or clear writes do not affect them. The outputs are enable levels, not gated clocks. A downstream clock-gating cell is expected to consume them.

Top module: `pclk_gate_bank`

## Requirements
- R1: After reset, every controllable enable is 0, so `periph_en` equals 64'h3.
- R2: Peripherals 0 and 1 always have `periph_en` high and always read as 1 in status bits 0 and 1 of offset 0x08. Writes to those bits through 0x00 or 0x04 have no effect.
- R3: A write to offset 0x00 sets the enable of peripheral `i` (2..31) for each data bit `i` that is 1. Enables whose data bit is 0 keep their value.
- R4: A write to offset 0x04 clears the enable of peripheral `i` (2..31) for each data bit `i` that is 1. Enables whose data bit is 0 keep their value.
- R5: A write to offset 0x10 sets, and a write to offset 0x14 clears, the enable of peripheral 32+`i` for each data bit `i` that is 1. All other enables are untouched.
- R6: In the same cycle, a read of offset 0x08 returns enables 31..0 and a read of offset 0x18 returns enables 63..32, with bit `i` of the data holding enable `i` of that bank.
- R7: Reads of 0x00, 0x04, 0x10, 0x14 and of unmapped offsets return 0. Writes to status or unmapped offsets change no enable.
- R8: An enable changes only at the clock edge that ends the write cycle. It holds its value in any cycle where `bus_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and enable clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe; one write per cycle in which it is high |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| periph_en | output | 64 | One clock enable per peripheral |

## Verification
The assertions assume that `bus_addr`, `bus_wdata` and `bus_we` are stable around each rising edge, and that a single register is addressed per cycle. Under these assumptions, the sampled previous-cycle write fully explains each enable change. The stimulus changes inputs only on falling edges and drops the write strobe after one cycle. It also always presents a defined address, including during idle cycles, so the combinational read-zero and status checks never see unknown values.

// File: rtl/pclk_gate_bank.sv
module pclk_gate_bank #(
  parameter int NUM_PERIPH = 64,
  parameter int ALWAYS_ON  = 2,
  parameter int ADDR_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  input  logic                  bus_we,
  output logic [31:0]           bus_rdata,
  output logic [NUM_PERIPH-1:0] periph_en
);
  localparam int NBANK = (NUM_PERIPH + 31) / 32;
  localparam int PADW  = NBANK * 32;

  function automatic logic [PADW-1:0] low_ones(input int n);
    logic [PADW-1:0] m;
    m = '0;
    for (int i = 0; i < PADW; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [PADW-1:0] FIXED = low_ones(ALWAYS_ON);
  localparam logic [PADW-1:0] VALID = low_ones(NUM_PERIPH);
  localparam logic [PADW-1:0] CTRL  = VALID & ~FIXED;

  logic [PADW-1:0] en_q, set_vec, clr_vec;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign set_vec[b*32 +: 32] = (bus_we && bus_addr == ADDR_W'(b*16))     ? bus_wdata : '0;
    assign clr_vec[b*32 +: 32] = (bus_we && bus_addr == ADDR_W'(b*16 + 4)) ? bus_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= FIXED & VALID;
    else        en_q <= (((en_q | set_vec) & ~clr_vec) & CTRL) | (FIXED & VALID);

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++)
      if (bus_addr == ADDR_W'(b*16 + 8)) bus_rdata = en_q[b*32 +: 32];
  end

  assign periph_en = en_q[NUM_PERIPH-1:0];

  p_fixed_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == ADDR_W'(8) |-> (bus_rdata & FIXED[31:0]) == FIXED[31:0]);

  p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == ADDR_W'(0) |=>
      (en_q[31:0] & $past(bus_wdata) & CTRL[31:0]) == ($past(bus_wdata) & CTRL[31:0]));

  p_set_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == ADDR_W'(0) |=>
      (en_q[31:0] & ~$past(bus_wdata)) == ($past(en_q[31:0]) & ~$past(bus_wdata)));

  p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == ADDR_W'(4) |=>
      (en_q[31:0] & $past(bus_wdata) & CTRL[31:0]) == 32'h0);

  p_rd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[3:0] != 4'h8 |-> bus_rdata == 32'h0);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(en_q));

  if (NBANK > 1) begin : g_chk_hi
    p_status_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == ADDR_W'(8'h18) |-> bus_rdata == periph_en[63:32]);
  end
endmodule

// File: tb/test_pclk_gate_bank.sv
`timescale 1ns/1ps
module test_pclk_gate_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [63:0] periph_en;

  pclk_gate_bank i_pclk_gate_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .periph_en(periph_en));

  always #2 clk = ~clk;

  typedef struct {
    string       req;
    bit          on_en;
    logic [63:0] exp;
  } item_t;

  item_t       q[$];
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;
  logic [63:0] model = 64'h3;

  initial forever begin
    item_t it;
    logic [63:0] act;
    wait (q.size() > 0);
    #1;
    it = q.pop_front();
    act = it.on_en ? periph_en : {32'h0, bus_rdata};
    checks++;
    if (act !== it.exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
    end
  end

  task automatic push(input string req, input bit on_en, input logic [63:0] exp);
    item_t it;
    it.req = req; it.on_en = on_en; it.exp = exp;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    push("R8 no change before edge", 1'b1, model);
    case (a)
      8'h00: model[31:0]  = model[31:0]  | d;
      8'h04: model[31:0]  = model[31:0]  & ~d;
      8'h10: model[63:32] = model[63:32] | d;
      8'h14: model[63:32] = model[63:32] & ~d;
      default: ;
    endcase
    model[1:0] = 2'b11;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic chk_en(input string req);
    push(req, 1'b1, model);
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    push(req, 1'b0, {32'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_en("R1 reset enables");
    rd("R1 reset status0", 8'h08, 32'h3);
    rd("R1 reset status1", 8'h18, 32'h0);

    wr(8'h00, 32'h0000_00F0); chk_en("R3 set pattern A");
    rd("R6 status0 after set", 8'h08, model[31:0]);
    wr(8'h00, 32'h8000_000C); chk_en("R3 set pattern B keeps others");
    wr(8'h04, 32'h0000_0030); chk_en("R4 clear pattern");
    rd("R6 status0 after clear", 8'h08, model[31:0]);
    wr(8'h04, 32'h0000_0003); chk_en("R2 clear of fixed bits ignored");
    rd("R2 status0 fixed bits", 8'h08, model[31:0]);
    wr(8'h00, 32'h0000_0003); chk_en("R2 set of fixed bits no change");

    wr(8'h10, 32'h8000_0001); chk_en("R5 bank1 set");
    rd("R6 status1", 8'h18, model[63:32]);
    wr(8'h14, 32'h8000_0000); chk_en("R5 bank1 clear");
    rd("R6 status1 after clear", 8'h18, model[63:32]);

    rd("R7 read set0", 8'h00, 32'h0);
    rd("R7 read clear0", 8'h04, 32'h0);
    rd("R7 read set1", 8'h10, 32'h0);
    rd("R7 read clear1", 8'h14, 32'h0);
    rd("R7 read unmapped", 8'h0C, 32'h0);
    rd("R7 read unmapped high", 8'h28, 32'h0);
    wr(8'h08, 32'hFFFF_FFFF); chk_en("R7 write status0 ignored");
    wr(8'h18, 32'hFFFF_FFFF); chk_en("R7 write status1 ignored");
    wr(8'h20, 32'hFFFF_FFFF); chk_en("R7 write unmapped ignored");

    @(negedge clk); bus_addr = 8'h00; bus_wdata = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    chk_en("R8 hold while strobe low");

    wr(8'h00, 32'hFFFF_FFFF); wr(8'h10, 32'hFFFF_FFFF); chk_en("R5 all set");
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF); chk_en("R4 all clear");
    rd("R2 status0 after full clear", 8'h08, 32'h3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule